// File: doc/BRIEF.md
# Register-File Gather Engine

This block runs a dynamic swizzle over its own 128-entry file of 64-bit registers. A command names three base registers: a destination vector, an index vector and a data vector. It also names a vector length VL. For each element position i, taken in ascending order, the engine reads an index from the index vector. It then writes one of two values into destination element i: the data register at that index, or zero when the index is not below VL. Every base-plus-offset register address wraps modulo 128.

The result must always equal running the elements one at a time as scalar moves. The index vector is read in the same order the destination is written, so it may share registers with the destination. The data vector is read out of order. When the destination range intersects the data range, the engine detects this at start and takes a slower path that commits each write before the next data read. No dependency is ever ignored. A debug port loads and inspects the register file while the engine is idle.

Top module: `gx_gather_engine`

## Requirements
- R1: For each i below VL, destination register (dst + i) mod 128 receives data register (dat + idx) mod 128. Here idx is the full 64-bit value of index register (ixb + i) mod 128, taken unsigned. When idx is greater than or equal to VL the destination receives zero. This holds even when only the upper bits of idx are set.
- R2: The final register contents equal those of strict element-by-element sequential execution. This includes the case where the index vector shares registers with the destination, or sits one register below it so that an element's index is the value just written by the previous element.
- R3: `slow_o` is 1 when the circular destination range [dst, dst+VL-1] intersects the circular data range [dat, dat+VL-1], and 0 otherwise. It is captured when a command is accepted and holds until the next accepted command. Adjacent ranges that do not share a register count as disjoint.
- R4: On the fast path, `busy_o` is high for exactly VL+1 cycles.
- R5: On the slow path, `busy_o` is high for exactly 2*VL cycles, and each element's write commits before the next element's data read.
- R6: A command with VL=0 writes no register, never raises `busy_o`, and raises `done_o` in the cycle right after the command is accepted.
- R7: A VL above 64 is treated as 64.
- R8: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low after a run.
- R9: A debug write lands at the next clock edge when the engine is idle and is ignored while it is busy. The debug read data shows the addressed register combinationally.
- R10: After reset, `busy_o`, `done_o` and `slow_o` are 0. `start_i` is accepted only while the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Accept a command (idle only) |
| dst_base_i | input | 7 | Destination vector base register |
| ixb_base_i | input | 7 | Index vector base register |
| dat_base_i | input | 7 | Data vector base register |
| vl_i | input | 7 | Vector length, clamped to 64 |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| slow_o | output | 1 | Last command used the overlap-safe path |
| dbg_we_i | input | 1 | Debug write enable (idle only) |
| dbg_addr_i | input | 7 | Debug read/write register address |
| dbg_wdata_i | input | 64 | Debug write data |
| dbg_rdata_o | output | 64 | Debug read data |

## Verification
On every cycle, the assertions check four things:
- on the fast path, no data read hits the register whose write is still pending;
- `slow_o` stays stable during a run;
- the element counter stays within the clamped length;
- a finished run is always followed by a `done_o` pulse, and VL=0 completes at once.

The register values themselves come only from the bench's scenarios, which compare all 128 registers against a sequential model. These scenarios cover the swapping permutation, out-of-range indices, an index vector that shares or trails the destination, in-place and wrapped overlaps, adjacent ranges, clamped lengths and debug writes issued mid-run.

// File: rtl/gx_pkg.sv
package gx_pkg;
    localparam int unsigned GX_ADDR_W = 7;
    localparam int unsigned GX_DATA_W = 64;
    localparam int unsigned GX_DEPTH  = 1 << GX_ADDR_W;
    localparam int unsigned GX_MAX_VL = GX_DEPTH / 2;

    typedef logic [GX_ADDR_W-1:0] gx_addr_t;
    typedef logic [GX_DATA_W-1:0] gx_word_t;

    typedef enum logic {GX_IDLE, GX_RUN} gx_state_e;

    typedef struct packed {
        gx_state_e st;
        gx_addr_t  dst;
        gx_addr_t  ixb;
        gx_addr_t  dat;
        gx_addr_t  vl;
        gx_addr_t  rd;
        logic      slow;
        logic      done;
        logic      pv;
        gx_addr_t  pa;
        gx_word_t  pd;
    } gx_seq_s;
endpackage

// File: rtl/gx_regfile.sv
module gx_regfile #(
    parameter int unsigned ADDR_W = 7,
    parameter int unsigned DATA_W = 64,
    parameter int unsigned NRD    = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            waddr,
    input  logic [DATA_W-1:0]            wdata,
    input  logic [NRD-1:0][ADDR_W-1:0]   raddr,
    output logic [NRD-1:0][DATA_W-1:0]   rdata
);
    localparam int unsigned DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rdata[p] = mem_q[raddr[p]];
    end

    // R9: a write never targets an undefined register
    p_wr_addr_known_r9: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !$isunknown(waddr));
endmodule

// File: rtl/gx_overlap.sv
module gx_overlap #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic [ADDR_W-1:0] dst,
    input  logic [ADDR_W-1:0] dat,
    input  logic [ADDR_W-1:0] vl,
    output logic              hit
);
    logic [ADDR_W-1:0] fwd_gap;
    logic [ADDR_W-1:0] bwd_gap;

    always_comb begin
        fwd_gap = dat - dst;
        bwd_gap = dst - dat;
        hit     = (vl != '0) && ((fwd_gap < vl) || (bwd_gap < vl));
    end
endmodule

// File: rtl/gx_seq.sv
module gx_seq
    import gx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  gx_addr_t dst_i,
    input  gx_addr_t ixb_i,
    input  gx_addr_t dat_i,
    input  gx_addr_t vl_i,
    input  gx_word_t ix_rdata_i,
    input  gx_word_t dat_rdata_i,
    output gx_addr_t ix_raddr_o,
    output gx_addr_t dat_raddr_o,
    output logic     we_o,
    output gx_addr_t waddr_o,
    output gx_word_t wdata_o,
    output logic     busy_o,
    output logic     done_o,
    output logic     slow_o
);
    gx_seq_s  s_q, s_d;
    gx_addr_t vl_eff;
    logic     ov_hit;
    logic     issue;
    logic     last;
    gx_word_t ix_val;
    logic     in_rng;

    always_comb begin
        vl_eff = (vl_i > gx_addr_t'(GX_MAX_VL)) ? gx_addr_t'(GX_MAX_VL) : vl_i;
    end

    gx_overlap #(.ADDR_W(GX_ADDR_W)) u_ov (
        .dst (dst_i),
        .dat (dat_i),
        .vl  (vl_eff),
        .hit (ov_hit)
    );

    always_comb begin
        s_d         = s_q;
        s_d.done    = 1'b0;
        ix_raddr_o  = s_q.ixb + s_q.rd;
        // bypass the pending write: the index vector may trail the destination
        ix_val      = (s_q.pv && (s_q.pa == ix_raddr_o)) ? s_q.pd : ix_rdata_i;
        dat_raddr_o = s_q.dat + ix_val[GX_ADDR_W-1:0];
        in_rng      = ix_val < GX_DATA_W'(s_q.vl);
        issue       = (s_q.st == GX_RUN) && (s_q.rd < s_q.vl) && !(s_q.slow && s_q.pv);
        last        = (s_q.st == GX_RUN) && s_q.pv && !issue && (s_q.rd == s_q.vl);
        we_o        = (s_q.st == GX_RUN) && s_q.pv;
        waddr_o     = s_q.pa;
        wdata_o     = s_q.pd;

        unique case (s_q.st)
            GX_IDLE: begin
                if (start_i) begin
                    s_d.dst  = dst_i;
                    s_d.ixb  = ixb_i;
                    s_d.dat  = dat_i;
                    s_d.vl   = vl_eff;
                    s_d.rd   = '0;
                    s_d.pv   = 1'b0;
                    s_d.slow = ov_hit;
                    if (vl_eff == '0) begin
                        s_d.done = 1'b1;
                    end else begin
                        s_d.st = GX_RUN;
                    end
                end
            end
            GX_RUN: begin
                if (issue) begin
                    s_d.pv = 1'b1;
                    s_d.pa = s_q.dst + s_q.rd;
                    s_d.pd = in_rng ? dat_rdata_i : '0;
                    s_d.rd = s_q.rd + 1'b1;
                end else begin
                    s_d.pv = 1'b0;
                end
                if (last) begin
                    s_d.st   = GX_IDLE;
                    s_d.done = 1'b1;
                end
            end
            default: s_d.st = GX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q    <= '0;
            s_q.st <= GX_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o = (s_q.st == GX_RUN);
    assign done_o = s_q.done;
    assign slow_o = s_q.slow;

    // R3/R5: on the fast path a data read never meets the pending write
    p_fast_no_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && s_q.pv) |-> (dat_raddr_o != s_q.pa));
    // R3: mode flag fixed for the whole run
    p_slow_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(slow_o));
    // R7: length and counter stay bounded
    p_vl_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> ((s_q.vl <= gx_addr_t'(GX_MAX_VL)) && (s_q.rd <= s_q.vl)));
    // R8: end of a run is marked by done
    p_done_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);
    // R8: done and busy never together
    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);
    // R6: zero length completes at once
    p_zero_vl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (vl_i == '0)) |=> (done_o && !busy_o));
endmodule

// File: rtl/gx_gather_engine.sv
module gx_gather_engine
    import gx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [6:0]  dst_base_i,
    input  logic [6:0]  ixb_base_i,
    input  logic [6:0]  dat_base_i,
    input  logic [6:0]  vl_i,
    output logic        busy_o,
    output logic        done_o,
    output logic        slow_o,
    input  logic        dbg_we_i,
    input  logic [6:0]  dbg_addr_i,
    input  logic [63:0] dbg_wdata_i,
    output logic [63:0] dbg_rdata_o
);
    localparam int unsigned NRD = 3;

    gx_addr_t                      ix_raddr, dat_raddr, seq_waddr, rf_waddr;
    gx_word_t                      seq_wdata, rf_wdata;
    logic                          seq_we, rf_we, busy;
    logic [NRD-1:0][GX_ADDR_W-1:0] raddr;
    logic [NRD-1:0][GX_DATA_W-1:0] rdata;

    gx_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .dst_i       (dst_base_i),
        .ixb_i       (ixb_base_i),
        .dat_i       (dat_base_i),
        .vl_i        (vl_i),
        .ix_rdata_i  (rdata[0]),
        .dat_rdata_i (rdata[1]),
        .ix_raddr_o  (ix_raddr),
        .dat_raddr_o (dat_raddr),
        .we_o        (seq_we),
        .waddr_o     (seq_waddr),
        .wdata_o     (seq_wdata),
        .busy_o      (busy),
        .done_o      (done_o),
        .slow_o      (slow_o)
    );

    always_comb begin
        raddr[0] = ix_raddr;
        raddr[1] = dat_raddr;
        raddr[2] = dbg_addr_i;
        rf_we    = busy ? seq_we    : dbg_we_i;
        rf_waddr = busy ? seq_waddr : dbg_addr_i;
        rf_wdata = busy ? seq_wdata : dbg_wdata_i;
    end

    gx_regfile #(.ADDR_W(GX_ADDR_W), .DATA_W(GX_DATA_W), .NRD(NRD)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (raddr),
        .rdata (rdata)
    );

    assign busy_o      = busy;
    assign dbg_rdata_o = rdata[2];

    // R9: debug writes never reach the file during a run
    p_dbg_blocked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rf_we) |-> (rf_waddr == seq_waddr) && seq_we);
endmodule

// File: tb/tb_gx_gather_engine.sv
`timescale 1ns/1ps
module tb_gx_gather_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [6:0]  dst_base_i = '0, ixb_base_i = '0, dat_base_i = '0, vl_i = '0;
    logic        busy_o, done_o, slow_o;
    logic        dbg_we_i = 1'b0;
    logic [6:0]  dbg_addr_i = '0;
    logic [63:0] dbg_wdata_i = '0;
    logic [63:0] dbg_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [63:0] mdl [128];

    always #5 clk = ~clk;

    gx_gather_engine dut (.*);

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: run hung, act=running exp=finished");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic dbg_wr(input int a, input logic [63:0] v);
        @(negedge clk);
        dbg_we_i = 1'b1; dbg_addr_i = 7'(a); dbg_wdata_i = v;
        @(negedge clk);
        dbg_we_i = 1'b0;
        mdl[a] = v;
    endtask

    task automatic check_all(input string req);
        for (int a = 0; a < 128; a++) begin
            dbg_addr_i = 7'(a);
            #1;
            chk(dbg_rdata_o == mdl[a], req, dbg_rdata_o, mdl[a]);
        end
    endtask

    task automatic run_op(input int dst, input int ixb, input int dat, input int vl,
                          input bit exp_slow, input int exp_cyc, input string req,
                          input bit poke = 0, input int poke_addr = 0);
        int veff;
        int cyc;
        logic [63:0] ix;
        veff = (vl > 64) ? 64 : vl;
        for (int i = 0; i < veff; i++) begin
            ix = mdl[(ixb + i) % 128];
            mdl[(dst + i) % 128] = (ix < 64'(veff)) ? mdl[(dat + int'(ix)) % 128] : 64'd0;
        end
        @(negedge clk);
        start_i = 1'b1; dst_base_i = 7'(dst); ixb_base_i = 7'(ixb);
        dat_base_i = 7'(dat); vl_i = 7'(vl);
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (busy_o && cyc < 1000) begin
            if (poke && cyc == 1) begin
                dbg_we_i = 1'b1; dbg_addr_i = 7'(poke_addr); dbg_wdata_i = '1;
            end else begin
                dbg_we_i = 1'b0;
            end
            cyc++;
            @(negedge clk);
        end
        dbg_we_i = 1'b0;
        chk(cyc == exp_cyc, {req, " busy cycles (R4/R5)"}, 64'(cyc), 64'(exp_cyc));
        chk(done_o == 1'b1, {req, " done pulse R8"}, 64'(done_o), 64'd1);
        chk(slow_o == exp_slow, {req, " path flag R3"}, 64'(slow_o), 64'(exp_slow));
        @(negedge clk);
        chk(done_o == 1'b0, {req, " done width R8"}, 64'(done_o), 64'd0);
        check_all({req, " contents R1/R2"});
    endtask

    task automatic t_reset();
        chk(busy_o == 1'b0, "R10 busy", 64'(busy_o), 64'd0);
        chk(done_o == 1'b0, "R10 done", 64'(done_o), 64'd0);
        chk(slow_o == 1'b0, "R10 slow", 64'(slow_o), 64'd0);
    endtask

    task automatic t_fill();
        for (int a = 0; a < 128; a++) dbg_wr(a, 64'hA5A5_0000_0000_0000 ^ (64'(a) * 64'h9E37_79B9_7F4A_7C15));
        check_all("R9 debug load");
    endtask

    task automatic t_swap();
        // R1 swap with VL=2, index [1,0]; R9 debug write mid-run ignored
        dbg_wr(10, 64'd1); dbg_wr(11, 64'd0);
        run_op(30, 10, 20, 2, 1'b0, 3, "R1 swap", 1'b1, 127);
        chk(mdl[30] == mdl[21] && mdl[31] == mdl[20], "R1 swap model", mdl[30], mdl[21]);
    endtask

    task automatic t_range();
        // R1 indices >= VL, including high bits only, give zero
        dbg_wr(70, 64'd3); dbg_wr(71, 64'd4);
        dbg_wr(72, 64'h0000_0001_0000_0001); dbg_wr(73, 64'h8000_0000_0000_0001);
        run_op(40, 70, 20, 4, 1'b0, 5, "R1 out-of-range");
    endtask

    task automatic t_share();
        // R2 index vector equal to destination
        dbg_wr(90, 64'd2); dbg_wr(91, 64'd0); dbg_wr(92, 64'd3); dbg_wr(93, 64'd1);
        run_op(90, 90, 20, 4, 1'b0, 5, "R2 shared index");
        // R2 index vector trails destination by one
        dbg_wr(10, 64'd3); dbg_wr(11, 64'd1); dbg_wr(12, 64'd4); dbg_wr(13, 64'd0); dbg_wr(14, 64'd2);
        dbg_wr(79, 64'd2);
        run_op(80, 79, 10, 5, 1'b0, 6, "R2 trailing index");
    endtask

    task automatic t_overlap();
        // R5 in-place permutation
        dbg_wr(56, 64'd1); dbg_wr(57, 64'd0); dbg_wr(58, 64'd3); dbg_wr(59, 64'd2);
        run_op(50, 56, 50, 4, 1'b1, 8, "R5 in-place");
        // R5 wrapped overlap
        dbg_wr(40, 64'd1); dbg_wr(41, 64'd3); dbg_wr(42, 64'd0); dbg_wr(43, 64'd2);
        run_op(126, 40, 0, 4, 1'b1, 8, "R5 wrap overlap");
    endtask

    task automatic t_adjacent();
        // R3 boundary of overlap detection
        dbg_wr(50, 64'd3); dbg_wr(51, 64'd2); dbg_wr(52, 64'd1); dbg_wr(53, 64'd0);
        run_op(44, 50, 40, 4, 1'b0, 5, "R3 adjacent disjoint");
        run_op(43, 50, 40, 4, 1'b1, 8, "R3 one shared reg");
    endtask

    task automatic t_wrap();
        // R1 destination wraps past register 127, fast path
        dbg_wr(100, 64'd5); dbg_wr(101, 64'd0); dbg_wr(102, 64'd6);
        dbg_wr(103, 64'd1); dbg_wr(104, 64'd2); dbg_wr(105, 64'd7);
        run_op(125, 100, 60, 6, 1'b0, 7, "R1 wrap fast R4");
    endtask

    task automatic t_zero();
        // R6 zero length even with coinciding ranges
        run_op(5, 6, 5, 0, 1'b0, 0, "R6 zero length");
    endtask

    task automatic t_clamp();
        // R7 length 127 acts as 64: ranges 0..63 and 64..127 disjoint
        dbg_wr(64, 64'd5); dbg_wr(65, 64'd63);
        run_op(0, 64, 64, 127, 1'b0, 65, "R7 clamp");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_swap();
        t_range();
        t_share();
        t_overlap();
        t_adjacent();
        t_wrap();
        t_zero();
        t_clamp();
        summary();
        $finish;
    end
endmodule